// File: doc/BRIEF.md
# Quad-SPI Flash Page-Program Sequencer

This block sits on the host side of a serial NOR flash and writes one page of data using the quad-data program command. A client makes a request with a 24-bit start address and a byte count, then streams the bytes through a valid/ready data port. The sequencer runs two chip-select frames on its own. The first frame carries the write-enable command. After a programmable chip-select-high gap, the second frame carries the program opcode and the address. Both of these go out serially on line 0. The data then follows on all four I/O lines, high nibble first.

The serial clock comes from the system clock through a programmable half-period divider. SCK idles low (SPI mode 0), and every line changes only while SCK is low, so each bit is stable at the rising edge. The I/O lines are presented as an output value plus a per-line output enable. Only line 0 is enabled in the single-line phases, and all four are enabled in the data phase.

If the data source stalls, SCK is held low until the next byte arrives, so no partial nibbles are ever clocked out. Requests with a bad byte count, or made while the quad-enable input is low, are refused with a one-cycle pulse and cause no bus activity. Completion is signalled when chip select rises at the end of the program frame. Polling the flash for the end of its internal program cycle is left to the client.

Top module: `qspi_page_writer`

## Requirements
- R1: An accepted request first produces a frame of exactly 8 SCK rising edges, carrying opcode 0x06 MSB first on sio_out[0], closed by chip select returning high.
- R2: Between the write-enable frame and the program frame, spi_cs_n stays high for at least max(1, cs_gap) system clocks.
- R3: The program frame begins with opcode 0x32 and then the 24-bit address MSB first, one bit per rising edge on sio_out[0], over its first 32 rising edges. During these edges sio_oe equals 4'b0001.
- R4: After the header, each data byte takes two rising edges with sio_oe = 4'b1111. The first edge carries bits 7..4 and the second carries bits 3..0, with the lower bit on sio_out[0] in each case. The program frame has exactly 32 + 2*len rising edges.
- R5: A request with req_len from 1 to 256 is accepted. A request with req_len = 0 or req_len > 256 gives a one-cycle rejected pulse, with no chip-select activity and no done.
- R6: A request made while qe_ok is low is rejected in the same way as a bad length.
- R7: spi_sck is low whenever spi_cs_n is high. Each SCK high phase and each SCK low phase inside a frame lasts at least max(1, half_div) system clocks.
- R8: While the sequencer waits for a data byte (data_ready high), SCK stays low. A stalled source adds no rising edges and does not alter the data sent.
- R9: done is a single-cycle pulse in the cycle in which spi_cs_n rises after the last data nibble. req_ready stays low from acceptance until that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qe_ok | input | 1 | Quad-enable bit known set in the flash |
| half_div | input | 8 | SCK half period in system clocks (0 treated as 1) |
| cs_gap | input | 8 | Minimum chip-select-high clocks between frames (0 treated as 1) |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 24 | Flash start address |
| req_len | input | 9 | Number of data bytes |
| data_valid | input | 1 | data_byte holds a byte |
| data_ready | output | 1 | Sequencer takes data_byte this cycle if valid |
| data_byte | input | 8 | Payload byte |
| done | output | 1 | Pulse when the program frame closes |
| rejected | output | 1 | Pulse when a request is refused |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| sio_out | output | 4 | I/O line output values |
| sio_oe | output | 4 | I/O line output enables |

## Verification
The checker assumes that half_div and cs_gap are held steady while a transaction runs. It also assumes that a requester keeps req_valid and its fields until req_ready, and that a data source holds data_byte unchanged while data_valid waits for data_ready. The bench changes the divider and gap settings only while the sequencer is idle. It raises each request at a falling clock edge and holds it across the accepting edge. It keeps each byte on the data port until it sees data_ready, and it inserts stalls only between whole bytes, so all stimulus stays within these assumptions.

// File: rtl/qspi_pw_pkg.sv
// Shared types for the quad page-program sequencer.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package qspi_pw_pkg;

    // Sequencer control states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SER   = 3'd1,
        ST_GAP   = 3'd2,
        ST_FETCH = 3'd3,
        ST_QUAD  = 3'd4
    } pw_state_t;

    // Which I/O lines the frame currently drives.
    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_ONE  = 2'd1,
        LANE_FOUR = 2'd2
    } lane_mode_t;

    localparam int unsigned NUM_LINES = 4;

endpackage

// File: rtl/qspi_pw_halfclk.sv
// Half-period timer for SCK generation.
// Produces a one-cycle tick every max(1,half_len) clocks while run is high.
// The count restarts from zero each time run goes low, so the first half
// phase after entering a shifting state always has the full length.
// Assumes half_len is steady while run is high.
module qspi_pw_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // Clamp a zero setting to the shortest legal half period.
    always_comb begin
        lim = (half_len == '0) ? DIV_W'(1) : half_len;
    end

    assign tick = run && (cnt_q == lim - DIV_W'(1));

    // Count system clocks inside the current half phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/qspi_pw_gap.sv
// Chip-select high-time guard between frames.
// expired rises once max(1,gap_len) cycles have passed since clear fell.
// Assumes gap_len is steady while clear is low.
module qspi_pw_gap #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [GAP_W-1:0] gap_len,
    output logic             expired
);
    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] lim;

    // Zero means one cycle, the smallest gap the sequencer can produce.
    always_comb begin
        lim = (gap_len == '0) ? GAP_W'(1) : gap_len;
    end

    assign expired = !clear && (cnt_q >= lim - GAP_W'(1));

    // Count gap cycles and saturate once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + GAP_W'(1);
        end
    end
endmodule

// File: rtl/qspi_pw_lanes.sv
// I/O line steering for the four flash data lines.
// In single-line mode only line 0 is enabled and carries ser_bit. In quad
// mode all lines are enabled and carry the selected nibble of the byte.
// Pure combinational; assumes its inputs change only while SCK is low.
module qspi_pw_lanes
    import qspi_pw_pkg::*;
(
    input  lane_mode_t                mode,
    input  logic                      ser_bit,
    input  logic                      low_nibble,
    input  logic [7:0]                byte_in,
    output logic [NUM_LINES-1:0]      line_out,
    output logic [NUM_LINES-1:0]      line_oe
);
    logic [NUM_LINES-1:0] nib;

    // Pick the nibble for the current quad clock: upper half first.
    always_comb begin
        nib = low_nibble ? byte_in[3:0] : byte_in[7:4];
    end

    // Per-line enable and value, same rule for every line but line 0.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (g == 0) begin : g_first
            assign line_oe[g]  = (mode == LANE_FOUR) || (mode == LANE_ONE);
            assign line_out[g] = (mode == LANE_FOUR) ? nib[g] :
                                 (mode == LANE_ONE)  ? ser_bit : 1'b0;
        end else begin : g_rest
            assign line_oe[g]  = (mode == LANE_FOUR);
            assign line_out[g] = (mode == LANE_FOUR) ? nib[g] : 1'b0;
        end
    end
endmodule

// File: rtl/qspi_page_writer.sv
// Quad page-program sequencer, top level.
// Runs a write-enable frame, waits a chip-select gap, then sends the program
// opcode and address on line 0 followed by the payload on four lines, high
// nibble first. SCK idles low (mode 0); lines change only on SCK falling
// phases. Assumes half_div and cs_gap are steady during a transaction and
// that the data source holds data_byte while data_valid waits.
module qspi_page_writer
    import qspi_pw_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          MAX_BYTES = 256,
    parameter int          DIV_W     = 8,
    parameter int          GAP_W     = 8,
    parameter logic [7:0]  WREN_OP   = 8'h06,
    parameter logic [7:0]  PROG_OP   = 8'h32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              qe_ok,
    input  logic [DIV_W-1:0]                  half_div,
    input  logic [GAP_W-1:0]                  cs_gap,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0]    req_len,
    input  logic                              data_valid,
    output logic                              data_ready,
    input  logic [7:0]                        data_byte,
    output logic                              done,
    output logic                              rejected,
    output logic                              spi_cs_n,
    output logic                              spi_sck,
    output logic [3:0]                        sio_out,
    output logic [3:0]                        sio_oe
);
    localparam int LEN_W  = $clog2(MAX_BYTES + 1);
    localparam int HDR_W  = 8 + ADDR_W;
    localparam int BIT_W  = $clog2(HDR_W + 1);
    localparam logic [BIT_W-1:0] WREN_LAST = BIT_W'(7);
    localparam logic [BIT_W-1:0] PROG_LAST = BIT_W'(HDR_W - 1);

    pw_state_t          state_q;
    logic               cs_n_q;
    logic               sck_q;
    logic [HDR_W-1:0]   hdr_q;
    logic [BIT_W-1:0]   bit_q;
    logic               prog_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   left_q;
    logic [7:0]         byte_q;
    logic               nib_lo_q;
    logic               done_q;
    logic               rej_q;

    logic               shift_run;
    logic               tick;
    logic               gap_done;
    logic               len_bad;
    logic [BIT_W-1:0]   ser_last;
    lane_mode_t         lane_mode;

    // SCK timer runs only in the two states that toggle the clock.
    assign shift_run = (state_q == ST_SER) || (state_q == ST_QUAD);

    qspi_pw_halfclk #(
        .DIV_W    (DIV_W)
    ) u_halfclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (shift_run),
        .half_len (half_div),
        .tick     (tick)
    );

    qspi_pw_gap #(
        .GAP_W    (GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q != ST_GAP),
        .gap_len  (cs_gap),
        .expired  (gap_done)
    );

    // Decode length legality and the header length of the current frame.
    always_comb begin
        len_bad  = (req_len == '0) || (req_len > LEN_W'(MAX_BYTES));
        ser_last = prog_q ? PROG_LAST : WREN_LAST;
    end

    // Map the control state onto the line drive mode.
    always_comb begin
        unique case (state_q)
            ST_SER:            lane_mode = LANE_ONE;
            ST_FETCH, ST_QUAD: lane_mode = LANE_FOUR;
            default:           lane_mode = LANE_OFF;
        endcase
    end

    qspi_pw_lanes u_lanes (
        .mode       (lane_mode),
        .ser_bit    (hdr_q[HDR_W-1]),
        .low_nibble (nib_lo_q),
        .byte_in    (byte_q),
        .line_out   (sio_out),
        .line_oe    (sio_oe)
    );

    // Main sequencer: frames, gap, byte fetch and nibble clocking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cs_n_q   <= 1'b1;
            sck_q    <= 1'b0;
            hdr_q    <= '0;
            bit_q    <= '0;
            prog_q   <= 1'b0;
            addr_q   <= '0;
            left_q   <= '0;
            byte_q   <= '0;
            nib_lo_q <= 1'b0;
            done_q   <= 1'b0;
            rej_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!qe_ok || len_bad) begin
                            rej_q <= 1'b1;
                        end else begin
                            addr_q  <= req_addr;
                            left_q  <= req_len;
                            hdr_q   <= {WREN_OP, {ADDR_W{1'b0}}};
                            prog_q  <= 1'b0;
                            bit_q   <= '0;
                            cs_n_q  <= 1'b0;
                            sck_q   <= 1'b0;
                            state_q <= ST_SER;
                        end
                    end
                end
                ST_SER: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q <= 1'b0;
                            if (bit_q == ser_last) begin
                                if (prog_q) begin
                                    state_q <= ST_FETCH;
                                end else begin
                                    cs_n_q  <= 1'b1;
                                    state_q <= ST_GAP;
                                end
                            end else begin
                                bit_q <= bit_q + BIT_W'(1);
                                hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        hdr_q   <= {PROG_OP, addr_q};
                        prog_q  <= 1'b1;
                        bit_q   <= '0;
                        cs_n_q  <= 1'b0;
                        state_q <= ST_SER;
                    end
                end
                ST_FETCH: begin
                    if (data_valid) begin
                        byte_q   <= data_byte;
                        nib_lo_q <= 1'b0;
                        state_q  <= ST_QUAD;
                    end
                end
                ST_QUAD: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q <= 1'b0;
                            if (!nib_lo_q) begin
                                nib_lo_q <= 1'b1;
                            end else if (left_q == LEN_W'(1)) begin
                                left_q  <= '0;
                                cs_n_q  <= 1'b1;
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else begin
                                left_q  <= left_q - LEN_W'(1);
                                state_q <= ST_FETCH;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign data_ready = (state_q == ST_FETCH);
    assign done       = done_q;
    assign rejected   = rej_q;
    assign spi_cs_n   = cs_n_q;
    assign spi_sck    = sck_q;

endmodule

// File: rtl/qspi_page_writer_chk.sv
// Protocol checker for the quad page-program sequencer, bound to the top.
// Assumes the environment holds half_div and cs_gap during a transaction.
module qspi_page_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       data_valid,
    input logic       data_ready,
    input logic       done,
    input logic       rejected,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic [3:0] sio_oe
);
    // R7: clock parked low outside a frame
    a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R3 and R4: only the one-line or four-line enable patterns appear
    a_r3_oe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe == 4'b0000) || (sio_oe == 4'b0001) || (sio_oe == 4'b1111));

    // R4: four-line drive only inside a frame
    a_r4_quad_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe == 4'b1111) |-> !spi_cs_n);

    // R9: completion coincides with chip select going high
    a_r9_done_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && !$past(spi_cs_n)));

    // R9: no new request taken while a frame is open
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !req_ready);

    // R8: no rising edge while a byte is being waited for
    a_r8_no_clock_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> !spi_sck);

    // R8: a stalled source keeps the clock low in the next cycle too
    a_r8_stall_holds_sck: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !data_valid) |=> !spi_sck);

    // R5 and R6: refusal only from idle and without opening a frame
    a_r5_reject_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> ($past(req_ready) && spi_cs_n));
endmodule

bind qspi_page_writer qspi_page_writer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .data_valid (data_valid),
    .data_ready (data_ready),
    .done       (done),
    .rejected   (rejected),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .sio_oe     (sio_oe)
);

// File: tb/qspi_page_writer_bench.sv
// Directed bench for the quad page-program sequencer.
module qspi_page_writer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qe_ok = 1'b1;
    logic [7:0]  half_div = 8'd1;
    logic [7:0]  cs_gap = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [8:0]  req_len = '0;
    logic        data_valid = 1'b0;
    logic        data_ready;
    logic [7:0]  data_byte = '0;
    logic        done;
    logic        rejected;
    logic        spi_cs_n;
    logic        spi_sck;
    logic [3:0]  sio_out;
    logic [3:0]  sio_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qspi_page_writer u_qspi_page_writer (
        .clk(clk), .rst_n(rst_n), .qe_ok(qe_ok), .half_div(half_div),
        .cs_gap(cs_gap), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .data_valid(data_valid),
        .data_ready(data_ready), .data_byte(data_byte), .done(done),
        .rejected(rejected), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .sio_out(sio_out), .sio_oe(sio_oe)
    );

    // Bus monitor state, sampled on falling clock edges.
    logic [7:0] src [0:255];
    logic [3:0] s_nib [0:543];
    logic [3:0] s_oe [0:543];
    logic [7:0] f0_byte;
    int  f0_n, f1_n, fidx, gap_cnt, min_hi, min_lo, hi_run, lo_run;
    int  done_n, done_bad, rej_n, cs_fall_n, ready_bad, idle_bad, stall_bad;
    logic prev_sck = 1'b0, prev_cs = 1'b1;

    task automatic mon_clear();
        f0_byte = '0; f0_n = 0; f1_n = 0; fidx = 0; gap_cnt = 0;
        min_hi = 1 << 20; min_lo = 1 << 20; hi_run = 0; lo_run = 0;
        done_n = 0; done_bad = 0; rej_n = 0; cs_fall_n = 0;
        ready_bad = 0; idle_bad = 0; stall_bad = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && spi_sck && !prev_sck) begin
                if (fidx == 0) begin
                    f0_byte = {f0_byte[6:0], sio_out[0]};
                    f0_n++;
                end else if (fidx == 1 && f1_n < 544) begin
                    s_nib[f1_n] = sio_out;
                    s_oe[f1_n]  = sio_oe;
                    f1_n++;
                end
                if (lo_run < min_lo) min_lo = lo_run;
            end
            if (!spi_sck && prev_sck && hi_run < min_hi) min_hi = hi_run;
            hi_run = spi_sck ? hi_run + 1 : 0;
            lo_run = (!spi_sck && !spi_cs_n) ? lo_run + 1 : 0;
            if (spi_cs_n && !prev_cs) fidx++;
            if (!spi_cs_n && prev_cs) cs_fall_n++;
            if (spi_cs_n && fidx == 1 && f1_n == 0) gap_cnt++;
            if (done) begin
                done_n++;
                if (!(spi_cs_n && !prev_cs)) done_bad++;
            end
            if (rejected) rej_n++;
            if (req_ready && !spi_cs_n) ready_bad++;
            if (spi_cs_n && spi_sck) idle_bad++;
            if (data_ready && spi_sck) stall_bad++;
            prev_sck = spi_sck;
            prev_cs  = spi_cs_n;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic start_req(input logic [23:0] a, input int len);
        req_addr = a; req_len = 9'(len); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic feed(input int n, input int stall);
        for (int i = 0; i < n; i++) begin
            repeat (stall) @(negedge clk);
            data_valid = 1'b1;
            data_byte  = src[i];
            while (!data_ready) @(negedge clk);
            @(negedge clk);
            data_valid = 1'b0;
        end
    endtask

    // One full write with its bus-level checks.
    task automatic run_write(input logic [23:0] a, input int len,
                             input int dv, input int gp, input int stall);
        int exp_half, exp_gap, bad_hdr, bad_oe, bad_dat, waitc;
        logic [31:0] hdr;
        for (int i = 0; i < len; i++) src[i] = 8'((i * 37) + a[7:0] + 5);
        half_div = 8'(dv); cs_gap = 8'(gp);
        exp_half = (dv == 0) ? 1 : dv;
        exp_gap  = (gp == 0) ? 1 : gp;
        mon_clear();
        fork
            start_req(a, len);
            feed(len, stall);
        join
        waitc = 0;
        while (done_n == 0 && waitc < 20000) begin @(negedge clk); waitc++; end
        repeat (4) @(negedge clk);
        chk(fidx == 2, "R1", "frames closed", fidx, 2);
        chk(f0_n == 8, "R1", "wren clocks", f0_n, 8);
        chk(f0_byte == 8'h06, "R1", "wren opcode", f0_byte, 8'h06);
        chk(gap_cnt >= exp_gap, "R2", "cs gap", gap_cnt, exp_gap);
        hdr = '0; bad_oe = 0;
        for (int k = 0; k < 32; k++) begin
            hdr = {hdr[30:0], s_nib[k][0]};
            if (s_oe[k] != 4'b0001) bad_oe++;
        end
        bad_hdr = (hdr != {8'h32, a}) ? 1 : 0;
        chk(hdr[31:24] == 8'h32, "R3", "program opcode", hdr[31:24], 8'h32);
        chk(bad_hdr == 0, "R3", "address", hdr[23:0], a);
        chk(bad_oe == 0, "R3", "header oe errors", bad_oe, 0);
        chk(f1_n == 32 + 2 * len, "R4", "program clocks", f1_n, 32 + 2 * len);
        bad_dat = 0; bad_oe = 0;
        for (int j = 0; j < len && 33 + 2 * j < 544; j++) begin
            if ({s_nib[32 + 2 * j], s_nib[33 + 2 * j]} != src[j]) bad_dat++;
            if (s_oe[32 + 2 * j] != 4'hF || s_oe[33 + 2 * j] != 4'hF) bad_oe++;
        end
        chk(bad_dat == 0, "R4", "data byte errors", bad_dat, 0);
        chk(bad_oe == 0, "R4", "data oe errors", bad_oe, 0);
        chk(idle_bad == 0, "R7", "sck high with cs high", idle_bad, 0);
        chk(min_hi >= exp_half, "R7", "min sck high", min_hi, exp_half);
        chk(min_lo >= exp_half, "R7", "min sck low", min_lo, exp_half);
        chk(stall_bad == 0, "R8", "sck high while fetching", stall_bad, 0);
        chk(done_n == 1, "R9", "done pulses", done_n, 1);
        chk(done_bad == 0, "R9", "done off cs rise", done_bad, 0);
        chk(ready_bad == 0, "R9", "ready inside frame", ready_bad, 0);
        chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);
    endtask

    // A refused request: one pulse, no frame, no done.
    task automatic run_reject(input string req, input int len, input logic qe);
        qe_ok = qe;
        mon_clear();
        start_req(24'h00ABCD, len);
        repeat (6) @(negedge clk);
        chk(rej_n == 1, req, "reject pulses", rej_n, 1);
        chk(cs_fall_n == 0, req, "cs activity", cs_fall_n, 0);
        chk(done_n == 0, req, "done pulses", done_n, 0);
        chk(req_ready == 1'b1, req, "ready after reject", req_ready, 1);
        qe_ok = 1'b1;
    endtask

    task automatic t_reset();
        chk(spi_cs_n == 1'b1, "R7", "reset cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R7", "reset sck", spi_sck, 0);
        chk(sio_oe == 4'b0000, "R3", "reset oe", sio_oe, 0);
        chk(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
        chk(done == 1'b0, "R9", "reset done", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_write(24'h12A5C3, 4, 1, 3, 0);     // R1 R3 R4 basic
        run_write(24'hFEDCBA, 3, 3, 0, 0);     // R2 zero gap, R7 divide by 3
        run_write(24'h000001, 1, 0, 5, 0);     // R5 single byte, zero divider
        run_write(24'h3C0F00, 256, 1, 2, 0);   // R5 full page
        run_write(24'h5A5A5A, 5, 2, 1, 4);     // R8 stalled source
        run_reject("R5", 0, 1'b1);
        run_reject("R5", 257, 1'b1);
        run_reject("R6", 8, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule